// File: doc/BRIEF.md
# Triggered TDC Hit-Word Emulator

This block takes the place of a group of time-to-digital converter chips while a readout chain is under test. Each trigger starts one burst of synthetic hit words. The words have the same layout as real converter output, so the boards downstream cannot tell the difference. The burst is the same for every trigger. The number of words for each emulated converter, the length of each emulated signal, and the spacing between successive signals can all be programmed. All timestamps stay inside a 6.4 us window after the trigger, which is 64000 steps of 100 ps.

The converters are emulated one after another. Converter 0 goes first. For each converter, hit h produces two words: a leading-edge word at time h*gap, then a trailing-edge word at time h*gap+width. The channel number cycles through 0 to 31. Words leave on a valid/ready stream. When the last converter is finished, a single-cycle done flag fires. A trigger that arrives while a burst is still running is dropped, and a sticky overlap flag records it.

The block is built around a five-state machine:
- IDLE waits for a trigger.
- SETUP clears the hit generator for the current converter.
- EMIT offers words until the count runs out or the window end is crossed.
- ADVANCE moves to the next converter. After the last converter it moves to FINISH instead.
- FINISH pulses done and returns to IDLE.

The transitions are:
- IDLE to SETUP when a trigger is seen.
- SETUP to EMIT unconditionally.
- EMIT to ADVANCE when no word is left to emit.
- ADVANCE to SETUP when more converters remain.
- ADVANCE to FINISH after the last converter.
- FINISH to IDLE unconditionally.

Top module: `tdc_emu`

## Requirements
- R1: While reset is held and right after it, out_valid, done and overlap are all 0.
- R2: Word layout (27 bits by default), from the least significant bit upward: bits [18:0] hold the timestamp in 100 ps units, bits [23:19] hold the channel, bit 24 holds the edge (0 = leading, 1 = trailing), and bits [26:25] hold the converter index.
- R3: For converter t, word k belongs to hit h = k/2. Its edge is the low bit of k and its channel is h mod 32. A leading word has timestamp h*gap and a trailing word has timestamp h*gap+width.
- R4: Converter i emits at most the count in cfg_words bits [9i+8:9i]. A count above 256 is treated as 256, and a count of 0 emits no words.
- R5: Converters are emitted in ascending index order, and each one restarts its timestamps and channels at 0.
- R6: A word whose timestamp would be greater than 64000 is not emitted. The remaining words of that converter are skipped, and a timestamp of exactly 64000 is still emitted.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays the same. No word is lost or reordered under any ready pattern.
- R8: done is high for exactly one cycle after the final converter has finished, including when no words were emitted at all. done is never high at the same time as out_valid.
- R9: A trigger that arrives while a burst is in progress starts no new burst and sets overlap. overlap then stays at 1 until reset. A trigger while idle does not set overlap.
- R10: Repeated triggers with the same configuration produce identical word sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Trigger; a high level sampled while idle starts a burst |
| cfg_words | input | 36 | Word count for each converter, 9 bits per converter |
| cfg_width | input | 19 | Signal length from leading to trailing edge, in 100 ps units |
| cfg_gap | input | 19 | Spacing between successive leading edges, in 100 ps units |
| out_valid | output | 1 | A word is on out_data |
| out_ready | input | 1 | The consumer accepts the word this cycle |
| out_data | output | 27 | Hit word |
| done | output | 1 | Single-cycle end-of-burst flag |
| overlap | output | 1 | Sticky flag for a trigger that was dropped |

## Verification
The bench targets these corner cases, each paired with the symptom a faulty design would show:
- An odd word count: a faulty design would drop the final leading word or add a trailing word that should not exist.
- A count above 256: a faulty design would wrap the count to a small value instead of clamping it.
- A timestamp of exactly 64000, and one just past it: a faulty design would cut off a legal word or let an illegal one through.
- Channel wrap after hit 31 and the reset of channels at each new converter: a faulty design would show a channel that keeps counting upward.
- Random back-pressure: a faulty design would drop or repeat words.
- A second trigger in the middle of a burst: a faulty design would emit a second burst or a second done pulse.
- An all-zero configuration: a faulty design would never assert done.

// File: rtl/tdc_emu_pkg.sv
package tdc_emu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_EMIT,
        ST_ADVANCE,
        ST_FINISH
    } emu_state_t;

endpackage

// File: rtl/tdc_emu_count_sel.sv
module tdc_emu_count_sel #(
    parameter int NUM_TDC   = 4,
    parameter int MAX_WORDS = 256,
    parameter int CNT_BITS  = 9,
    parameter int IDX_BITS  = 2
) (
    input  logic [NUM_TDC*CNT_BITS-1:0] cfg_words,
    input  logic [IDX_BITS-1:0]         idx,
    output logic [CNT_BITS-1:0]         limit
);
    localparam logic [CNT_BITS-1:0] MAX_CNT = CNT_BITS'(MAX_WORDS);

    logic [CNT_BITS-1:0] clamped [NUM_TDC];

    for (genvar g = 0; g < NUM_TDC; g++) begin : g_clamp
        logic [CNT_BITS-1:0] raw;
        assign raw        = cfg_words[g*CNT_BITS +: CNT_BITS];
        assign clamped[g] = (raw > MAX_CNT) ? MAX_CNT : raw;
    end

    always_comb begin
        limit = '0;
        for (int i = 0; i < NUM_TDC; i++) begin
            if (idx == i[IDX_BITS-1:0]) begin
                limit = clamped[i];
            end
        end
    end

endmodule

// File: rtl/tdc_emu_hit_gen.sv
module tdc_emu_hit_gen #(
    parameter int TS_BITS  = 19,
    parameter int CH_BITS  = 5,
    parameter int CNT_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                step,
    input  logic [TS_BITS-1:0]  width,
    input  logic [TS_BITS-1:0]  gap,
    output logic [CNT_BITS-1:0] word_idx,
    output logic                edge_bit,
    output logic [CH_BITS-1:0]  channel,
    output logic [TS_BITS:0]    stamp
);
    logic [TS_BITS:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word_idx <= '0;
            base_q   <= '0;
            channel  <= '0;
        end else if (step) begin
            word_idx <= word_idx + 1'b1;
            if (word_idx[0]) begin
                base_q  <= base_q + {1'b0, gap};
                channel <= channel + 1'b1;
            end
        end
    end

    assign edge_bit = word_idx[0];
    assign stamp    = edge_bit ? (base_q + {1'b0, width}) : base_q;

endmodule

// File: rtl/tdc_emu.sv
module tdc_emu #(
    parameter int NUM_TDC    = 4,
    parameter int MAX_WORDS  = 256,
    parameter int TS_BITS    = 19,
    parameter int CH_BITS    = 5,
    parameter int WINDOW_END = 64000,
    localparam int CNT_BITS  = $clog2(MAX_WORDS + 1),
    localparam int IDX_BITS  = (NUM_TDC > 1) ? $clog2(NUM_TDC) : 1,
    localparam int WORD_W    = IDX_BITS + 1 + CH_BITS + TS_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        trig,
    input  logic [NUM_TDC*CNT_BITS-1:0] cfg_words,
    input  logic [TS_BITS-1:0]          cfg_width,
    input  logic [TS_BITS-1:0]          cfg_gap,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [WORD_W-1:0]           out_data,
    output logic                        done,
    output logic                        overlap
);
    import tdc_emu_pkg::*;

    localparam logic [TS_BITS:0]    WIN_LIMIT = (TS_BITS + 1)'(WINDOW_END);
    localparam logic [IDX_BITS-1:0] LAST_TDC  = IDX_BITS'(NUM_TDC - 1);

    emu_state_t          state_q, state_d;
    logic [IDX_BITS-1:0] tdc_q;
    logic [CNT_BITS-1:0] limit;
    logic [CNT_BITS-1:0] word_idx;
    logic                edge_bit;
    logic [CH_BITS-1:0]  channel;
    logic [TS_BITS:0]    stamp;
    logic                have_word;
    logic                gen_clear, gen_step, tdc_next;

    tdc_emu_count_sel #(
        .NUM_TDC  (NUM_TDC),
        .MAX_WORDS(MAX_WORDS),
        .CNT_BITS (CNT_BITS),
        .IDX_BITS (IDX_BITS)
    ) u_count_sel (
        .cfg_words(cfg_words),
        .idx      (tdc_q),
        .limit    (limit)
    );

    tdc_emu_hit_gen #(
        .TS_BITS (TS_BITS),
        .CH_BITS (CH_BITS),
        .CNT_BITS(CNT_BITS)
    ) u_hit_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (gen_clear),
        .step    (gen_step),
        .width   (cfg_width),
        .gap     (cfg_gap),
        .word_idx(word_idx),
        .edge_bit(edge_bit),
        .channel (channel),
        .stamp   (stamp)
    );

    assign have_word = (word_idx < limit) && (stamp <= WIN_LIMIT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (trig) state_d = ST_SETUP;
            ST_SETUP:   state_d = ST_EMIT;
            ST_EMIT:    if (!have_word) state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = (tdc_q == LAST_TDC) ? ST_FINISH : ST_SETUP;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        done      = 1'b0;
        gen_clear = 1'b0;
        gen_step  = 1'b0;
        tdc_next  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_SETUP:   gen_clear = 1'b1;
            ST_EMIT: begin
                out_valid = have_word;
                gen_step  = have_word && out_ready;
            end
            ST_ADVANCE: tdc_next = (tdc_q != LAST_TDC);
            ST_FINISH:  done = 1'b1;
            default:    ;
        endcase
    end

    assign out_data = {tdc_q, edge_bit, channel, stamp[TS_BITS-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdc_q   <= '0;
            overlap <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && trig) begin
                tdc_q <= '0;
            end else if (tdc_next) begin
                tdc_q <= tdc_q + 1'b1;
            end
            if (trig && state_q != ST_IDLE) begin
                overlap <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdc_emu_checker.sv
module tdc_emu_checker #(
    parameter int WORD_W     = 27,
    parameter int TS_BITS    = 19,
    parameter int WINDOW_END = 64000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              done,
    input logic              overlap
);
    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_no_word: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    a_r9_overlap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overlap |=> overlap);

    a_r9_busy_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        trig && out_valid |=> overlap);

    a_r6_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[TS_BITS-1:0] <= WINDOW_END));

endmodule

bind tdc_emu tdc_emu_checker #(
    .WORD_W    (WORD_W),
    .TS_BITS   (TS_BITS),
    .WINDOW_END(WINDOW_END)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .done     (done),
    .overlap  (overlap)
);

// File: tb/tdc_emu_bench.sv
module tdc_emu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NT  = 4;
    localparam int CB  = 9;
    localparam int TSB = 19;
    localparam int WW  = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig = 1'b0;
    logic [NT*CB-1:0] cfg_words = '0;
    logic [TSB-1:0] cfg_width = '0;
    logic [TSB-1:0] cfg_gap = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [WW-1:0] out_data;
    logic          done;
    logic          overlap;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit stall_mode = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    string cur_tag = "R1";
    logic [WW-1:0] sb_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tdc_emu u_tdc_emu (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .cfg_words(cfg_words), .cfg_width(cfg_width), .cfg_gap(cfg_gap),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done), .overlap(overlap)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Ready driver: changes just after the rising edge
    always begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = stall_mode ? lfsr[0] : 1'b1;
    end

    // Monitor: pops expected words as they are accepted
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (sb_q.size() == 0) begin
                check(1'b0, {cur_tag, " R9 unexpected word"}, longint'(out_data), 0);
            end else begin
                logic [WW-1:0] exp_w;
                exp_w = sb_q.pop_front();
                check(out_data == exp_w, {cur_tag, " R2 R3 word"}, longint'(out_data), longint'(exp_w));
            end
        end
        if (rst_n && done) done_cnt++;
    end

    // Driver side: compute expected words from R2..R6
    task automatic expect_burst();
        for (int t = 0; t < NT; t++) begin
            int n;
            n = int'(cfg_words[t*CB +: CB]);
            if (n > 256) n = 256;
            for (int k = 0; k < n; k++) begin
                int h, ts;
                logic [WW-1:0] w;
                h  = k / 2;
                ts = h * int'(cfg_gap) + ((k % 2 == 1) ? int'(cfg_width) : 0);
                if (ts > 64000) break;
                w = {t[1:0], k[0], h[4:0], ts[18:0]};
                sb_q.push_back(w);
            end
        end
    endtask

    task automatic pulse_trig();
        @(posedge clk); #1 trig = 1'b1;
        @(posedge clk); #1 trig = 1'b0;
    endtask

    task automatic set_cfg(input int c0, input int c1, input int c2, input int c3,
                           input int wid, input int gp);
        cfg_words = {c3[CB-1:0], c2[CB-1:0], c1[CB-1:0], c0[CB-1:0]};
        cfg_width = wid[TSB-1:0];
        cfg_gap   = gp[TSB-1:0];
    endtask

    task automatic run_burst(input string tag, input bit stall, input bit extra_trig);
        int start;
        int waited;
        cur_tag = tag;
        stall_mode = stall;
        expect_burst();
        start = done_cnt;
        pulse_trig();
        if (extra_trig) begin
            repeat (4) @(posedge clk);
            pulse_trig();
        end
        waited = 0;
        while (done_cnt == start && waited < 20000) begin
            @(posedge clk);
            waited++;
        end
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(sb_q.size() == 0, {tag, " R4 R6 words missing"}, sb_q.size(), 0);
        check(done_cnt - start == 1, {tag, " R8 done pulses"}, done_cnt - start, 1);
        sb_q.delete();
        stall_mode = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(overlap == 1'b0, "R1 overlap after reset", overlap, 0);
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

        set_cfg(3, 2, 0, 5, 7, 20);
        run_burst("R3 R5 basic", 1'b0, 1'b0);

        run_burst("R7 stalled", 1'b1, 1'b0);

        set_cfg(6, 300, 1, 0, 5000, 30000);
        run_burst("R4 R6 clamp and window", 1'b0, 1'b0);

        set_cfg(8, 0, 0, 2, 0, 32000);
        run_burst("R6 exact edge", 1'b1, 1'b0);

        set_cfg(0, 0, 0, 0, 3, 3);
        run_burst("R8 empty", 1'b0, 1'b0);

        set_cfg(256, 0, 0, 0, 1, 400);
        run_burst("R3 channel wrap", 1'b0, 1'b0);

        @(negedge clk);
        check(overlap == 1'b0, "R9 idle trigger no overlap", overlap, 0);

        set_cfg(10, 10, 10, 10, 3, 5);
        run_burst("R9 busy trigger", 1'b1, 1'b1);
        @(negedge clk);
        check(overlap == 1'b1, "R9 overlap set", overlap, 1);

        set_cfg(3, 2, 0, 5, 7, 20);
        run_burst("R10 repeat a", 1'b1, 1'b0);
        run_burst("R10 repeat b", 1'b0, 1'b0);
        @(negedge clk);
        check(overlap == 1'b1, "R9 overlap sticky", overlap, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule